// File: doc/BRIEF.md
# Banked Register and RAM Bus Interface

This block is the host-facing access path of a real-time clock device. A host drives one shared 8-bit bus that carries first an address, then data. A high pulse on the address strobe, taken while chip select is low, stores the location. Active-low read and write strobes then move a byte to or from that location. All inputs are sampled on the rising edge of the block clock.

The 128-location map is banked. Bank 0 shows fourteen clock/control registers, followed by a general-purpose RAM of 114 bytes. Bank 1 keeps the clock registers and the lower part of that RAM. Its upper half becomes a window onto a 4096-byte extended RAM. The host reaches that RAM indirectly: it loads a 12-bit pointer as two bytes, then moves data through one data location.

A power-fail input and a divider-hold input from the clock core both shut the host out. While locked, the block latches no address, performs no write, and never enables its bus driver. After power-fail is released, and after reset, access stays shut for a fixed number of cycles.

Top module: `rtc_bus_if`

## Requirements
- R1: A clock edge with `ale` high, `csN` low and access open stores `busIn[6:0]` as the current location. That location is held until the next such edge.
- R2: In bank 0, locations 0x00–0x0D are the clock registers and 0x0E–0x7F are the 114 bytes of user RAM. Every one of these locations can be written and read back.
- R3: The bank is chosen by bit 4 of clock register 0x0A: 0 means bank 0 and 1 means bank 1. Reset clears the bit, so the block starts in bank 0.
- R4: In bank 1, locations 0x00–0x3F reach the same clock registers and user RAM as in bank 0. Location 0x50 is the low byte of the extended pointer. Location 0x51 holds pointer bits 11:8 in its bits 3:0 and reads back with the upper nibble 0. Location 0x53 is the extended RAM byte at the pointer. Every other location from 0x40 to 0x7F reads 0x00 and ignores writes.
- R5: In any cycle where `rdN` and `csN` are low, `ale` is low and access is open, `busOe` is high and `busOut` carries the selected byte in that same cycle. Otherwise `busOe` is low, including during reset. A write takes effect at the clock edge where `wrN` and `csN` are low, `ale` is low and access is open.
- R6: While `pwrFail` is high, address strobes, reads and writes have no effect and `busOe` stays low.
- R7: After reset and after `pwrFail` falls, access stays closed for `REC_CYCLES` clock edges, which is 16 by default. Accesses attempted in that interval have no effect.
- R8: While `divHold` is high, access is closed. Access reopens on the first cycle after `divHold` falls, with no added delay.
- R9: With `csN` high, the address, read and write strobes have no effect and `busOe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busIn | input | 8 | Address/data from the host |
| busOut | output | 8 | Read data toward the host |
| busOe | output | 1 | Bus driver enable |
| pwrFail | input | 1 | Supply failing; locks out access |
| divHold | input | 1 | Divider chain held in reset; locks out access |

## Verification
Read data and the driver enable are combinational from the stored location, so they are due in the same cycle as the low read strobe. The monitor samples them on the falling edge inside that cycle. An address strobe or a write lands at the next rising edge, and every read that depends on it starts at least one edge later. A lockout ends `REC_CYCLES` edges after `pwrFail` falls, so the bench probes once right after the release and again only after `REC_CYCLES`+2 edges. A `divHold` release is probed on the very next cycle.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int MAP_AW = 7;
  localparam int MAP_SIZE = 1 << MAP_AW;

  typedef enum logic [2:0] {
    T_NONE, T_CLK, T_USER, T_EXTLO, T_EXTHI, T_EXTDATA
  } tgt_e;

  typedef struct packed {
    tgt_e              target;
    logic              wrEn;
    logic              rdEn;
    logic [MAP_AW-1:0] addr;
  } stb_t;
endpackage

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_bus_pkg::*;
#(
  parameter int CLK_REGS   = 14,
  parameter int REC_CYCLES = 16,
  parameter int WIN_BASE   = 'h40,
  parameter int EXT_LO     = 'h50,
  parameter int EXT_HI     = 'h51,
  parameter int EXT_DAT    = 'h53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [MAP_AW-1:0] addrIn,
  input  logic              pwrFail,
  input  logic              divHold,
  input  logic              bankSel,
  output stb_t              stb,
  output logic              busOe
);
  localparam int CW = $clog2(REC_CYCLES + 1);

  logic [CW-1:0]     recCnt;
  logic [MAP_AW-1:0] addrQ;
  logic              blocked;
  logic              sel;

  assign blocked = pwrFail | divHold | (recCnt != '0);
  assign sel     = !csN && !blocked;

  // recovery timer: loaded while failing and at reset, counts down after
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             recCnt <= CW'(REC_CYCLES);
    else if (pwrFail)      recCnt <= CW'(REC_CYCLES);
    else if (recCnt != '0) recCnt <= recCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           addrQ <= '0;
    else if (sel && ale) addrQ <= addrIn;
  end

  always_comb begin
    stb.addr = addrQ;
    stb.wrEn = sel && !ale && !wrN;
    stb.rdEn = sel && !ale && !rdN;
    if (int'(addrQ) < CLK_REGS)              stb.target = T_CLK;
    else if (!bankSel || int'(addrQ) < WIN_BASE) stb.target = T_USER;
    else if (int'(addrQ) == EXT_LO)          stb.target = T_EXTLO;
    else if (int'(addrQ) == EXT_HI)          stb.target = T_EXTHI;
    else if (int'(addrQ) == EXT_DAT)         stb.target = T_EXTDATA;
    else                                     stb.target = T_NONE;
  end

  assign busOe = stb.rdEn;

  a_r1_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !(ale && !csN) |=> $stable(stb.addr));
  a_r6_fail_locks: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> (!stb.wrEn && !busOe));
  a_r7_recovery_holds: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrFail) |-> (!stb.wrEn && !busOe));
  a_r8_hold_locks: assert property (@(posedge clk) disable iff (!rstN)
    divHold |-> (!stb.wrEn && !busOe));
  a_r9_cs_gates: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!stb.wrEn && !busOe));
endmodule

// File: rtl/rtc_bus_datapath.sv
module rtc_bus_datapath
  import rtc_bus_pkg::*;
#(
  parameter int CLK_REGS = 14,
  parameter int EXT_AW   = 12,
  parameter int BANK_REG = 10,
  parameter int BANK_BIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  stb_t       stb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       bankSel
);
  localparam int USER_N = MAP_SIZE - CLK_REGS;
  localparam int EXT_N  = 1 << EXT_AW;
  localparam int CIW    = $clog2(CLK_REGS);
  localparam int UIW    = $clog2(USER_N);
  localparam int HIW    = EXT_AW - 8;

  logic [7:0]        clkRegs [CLK_REGS];
  logic [7:0]        userRam [USER_N];
  logic [7:0]        extRam  [EXT_N];
  logic [EXT_AW-1:0] extAddr;
  logic [MAP_AW-1:0] userOff;
  logic [UIW-1:0]    userIdx;

  assign userOff = stb.addr - MAP_AW'(CLK_REGS);
  assign userIdx = userOff[UIW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CLK_REGS; i++) clkRegs[i] <= '0;
    end else if (stb.wrEn && stb.target == T_CLK) begin
      clkRegs[stb.addr[CIW-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extAddr <= '0;
    else if (stb.wrEn && stb.target == T_EXTLO) extAddr[7:0] <= wrData;
    else if (stb.wrEn && stb.target == T_EXTHI) extAddr[EXT_AW-1:8] <= wrData[HIW-1:0];
  end

  // storage arrays keep no reset: contents are meant to outlive it
  always_ff @(posedge clk) begin
    if (stb.wrEn && stb.target == T_USER)    userRam[userIdx] <= wrData;
    if (stb.wrEn && stb.target == T_EXTDATA) extRam[extAddr]  <= wrData;
  end

  always_comb begin
    case (stb.target)
      T_CLK:     rdData = clkRegs[stb.addr[CIW-1:0]];
      T_USER:    rdData = userRam[userIdx];
      T_EXTLO:   rdData = extAddr[7:0];
      T_EXTHI:   rdData = 8'(extAddr[EXT_AW-1:8]);
      T_EXTDATA: rdData = extRam[extAddr];
      default:   rdData = 8'h00;
    endcase
  end

  assign bankSel = clkRegs[BANK_REG][BANK_BIT];

  a_r3_bank_by_reg: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrEn && stb.target == T_CLK) |=> $stable(bankSel));
  a_r4_ptr_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrEn && (stb.target == T_EXTLO || stb.target == T_EXTHI)) |=> $stable(extAddr));
endmodule

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_bus_pkg::*;
#(
  parameter int CLK_REGS   = 14,
  parameter int EXT_AW     = 12,
  parameter int REC_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ale,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       busOe,
  input  logic       pwrFail,
  input  logic       divHold
);
  stb_t stb;
  logic bankSel;

  rtc_bus_ctrl #(.CLK_REGS(CLK_REGS), .REC_CYCLES(REC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ale(ale), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addrIn(busIn[MAP_AW-1:0]), .pwrFail(pwrFail), .divHold(divHold),
    .bankSel(bankSel), .stb(stb), .busOe(busOe)
  );

  rtc_bus_datapath #(.CLK_REGS(CLK_REGS), .EXT_AW(EXT_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busIn),
    .rdData(busOut), .bankSel(bankSel)
  );
endmodule

// File: tb/sim_rtc_bus_if.sv
module sim_rtc_bus_if;
  localparam int CLK_PERIOD = 10;
  localparam int REC = 16;

  logic clk = 0, rstN = 0, ale = 0, csN = 1, rdN = 1, wrN = 1;
  logic pwrFail = 0, divHold = 0;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic busOe;
  logic probe = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] qData[$];
  logic       qOe[$];
  string      qTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bus_if #(.REC_CYCLES(REC)) u0 (
    .clk(clk), .rstN(rstN), .ale(ale), .csN(csN), .rdN(rdN), .wrN(wrN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .pwrFail(pwrFail), .divHold(divHold)
  );

  // monitor: pops one expected item per probed read cycle
  always @(negedge clk) begin
    if (probe && qTag.size() > 0) begin
      logic [7:0] d; logic o; string t;
      d = qData.pop_front(); o = qOe.pop_front(); t = qTag.pop_front();
      checks++;
      if (busOe !== o || (o && busOut !== d)) begin
        errors++;
        $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h", t, busOe, busOut, o, d);
      end
    end
  end

  task automatic setAddr(input logic [7:0] a, input logic cs);
    @(posedge clk); #1;
    csN = cs; ale = 1; busIn = a;
    @(posedge clk); #1;
    ale = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic cs = 0);
    setAddr(a, cs);
    wrN = 0; busIn = d;
    @(posedge clk); #1;
    wrN = 1; csN = 1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] d, input logic o,
                    input string tag, input logic cs = 0);
    setAddr(a, cs);
    qData.push_back(d); qOe.push_back(o); qTag.push_back(tag);
    rdN = 0; probe = 1;
    @(posedge clk); #1;
    rdN = 1; probe = 0; csN = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    checks++;
    if (busOe !== 1'b0) begin
      errors++; $display("FAIL R5 reset: oe=%0b expected 0", busOe);
    end
    idle(2); rstN = 1;
    // R7: access closed right after reset
    rd(8'h03, 8'h00, 1'b0, "R7 post-reset lockout");
    idle(REC + 2);

    // R2 bank 0 map
    wr(8'h03, 8'h5A);
    rd(8'h03, 8'h5A, 1'b1, "R2 clock register");
    wr(8'h0E, 8'h11);
    wr(8'h7F, 8'h22);
    wr(8'h20, 8'h77);
    wr(8'h50, 8'h99);
    rd(8'h0E, 8'h11, 1'b1, "R2 first user byte");
    rd(8'h7F, 8'h22, 1'b1, "R2 last user byte");
    rd(8'h0A, 8'h00, 1'b1, "R3 bank bit reset");

    // R9 chip select high
    wr(8'h0E, 8'hEE, 1'b1);
    rd(8'h0E, 8'h00, 1'b0, "R9 read with cs high", 1'b1);
    rd(8'h0E, 8'h11, 1'b1, "R9 write with cs high ignored");

    // R3/R4 bank 1 and extended RAM
    wr(8'h0A, 8'h10);
    wr(8'h50, 8'h34);
    wr(8'h51, 8'hF2);
    rd(8'h51, 8'h02, 1'b1, "R4 pointer high nibble");
    rd(8'h50, 8'h34, 1'b1, "R4 pointer low byte");
    wr(8'h53, 8'hA5);
    wr(8'h50, 8'h35);
    wr(8'h53, 8'h3C);
    rd(8'h53, 8'h3C, 1'b1, "R4 ext data at 0x235");
    wr(8'h50, 8'h34);
    rd(8'h53, 8'hA5, 1'b1, "R4 ext data at 0x234");
    wr(8'h60, 8'h55);
    rd(8'h60, 8'h00, 1'b1, "R4 unused window location");
    rd(8'h7F, 8'h00, 1'b1, "R4 upper user RAM hidden");
    rd(8'h20, 8'h77, 1'b1, "R4 lower user RAM shared");
    rd(8'h03, 8'h5A, 1'b1, "R4 clock regs in bank 1");
    wr(8'h0A, 8'h00);
    rd(8'h50, 8'h99, 1'b1, "R3 back in bank 0, user byte intact");

    // R1 address held without a new strobe
    setAddr(8'h7F, 1'b0);
    csN = 1; busIn = 8'h0E;
    @(posedge clk); #1;
    csN = 0; qData.push_back(8'h22); qOe.push_back(1'b1); qTag.push_back("R1 address held");
    rdN = 0; probe = 1;
    @(posedge clk); #1;
    rdN = 1; probe = 0; csN = 1;

    // R6 power fail
    pwrFail = 1;
    wr(8'h0E, 8'hEE);
    rd(8'h0E, 8'h00, 1'b0, "R6 read during fail");
    @(posedge clk); #1; pwrFail = 0;
    // R7 recovery window
    wr(8'h0E, 8'hDD);
    rd(8'h0E, 8'h00, 1'b0, "R7 read in recovery");
    idle(REC + 2);
    rd(8'h0E, 8'h11, 1'b1, "R6 R7 no write landed");

    // R8 divider hold
    divHold = 1;
    wr(8'h0E, 8'h44);
    rd(8'h0E, 8'h00, 1'b0, "R8 read while held");
    divHold = 0;
    rd(8'h0E, 8'h11, 1'b1, "R8 immediate reopen, no write landed");

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule